// File: doc/BRIEF.md
# DFI Software Command Injector

This block sits between the memory controller and the PHY. On one side it has a 32-bit register port that a bus master uses. On the other side it has a single-phase DFI command interface. It has two modes.

In software mode, firmware writes the memory command bits, the row/column address, the bank and the clock-enable, termination and reset levels into registers. A write to the issue register then places the stored command on the command lines for exactly one cycle. Every other cycle carries a NOP. Firmware uses this mode to bring the memory up: reset release, mode-register loads and ZQ calibration. It then sets the select bit, which hands the interface over to the controller.

In hardware mode the controller's command phase goes to the outputs unchanged, in the same cycle.

Top module: `dfi_cmd_injector`

## Requirements
- R1: After reset all registers are 0. The block is in software mode with `dfi_cke`, `dfi_odt` and `dfi_reset_n` low, the four command lines (`dfi_cs_n`, `dfi_ras_n`, `dfi_cas_n`, `dfi_we_n`) high and both data enables low.
- R2: Register byte offsets are control 0x00, command 0x04, issue 0x08, address 0x0C and bank 0x10.
  - A read returns the stored value in the low bits: control 4 bits, command 6 bits, address 16 bits, bank 3 bits.
  - All bits above those read as 0.
  - Read data and `bus_rvalid` appear in the cycle after the read request.
- R3: Control bit 0 selects hardware mode, bit 1 is CKE, bit 2 is ODT and bit 3 is RESET_N. In software mode, `dfi_cke`, `dfi_odt` and `dfi_reset_n` follow these bits from the cycle after the write, whether or not a command is issued.
- R4: In software mode, `dfi_address` and `dfi_bank` equal the address and bank registers on every cycle.
- R5: A write to offset 0x08 with data bit 0 set issues the stored command in the cycle after the write, for exactly one cycle. The command register holds active-high bits: bit 0 CS, bit 1 WE, bit 2 CAS, bit 3 RAS, bit 4 write-data enable, bit 5 read-data enable. During the issue cycle:
  - each of `dfi_cs_n`, `dfi_we_n`, `dfi_cas_n` and `dfi_ras_n` is the inverse of its bit;
  - `dfi_wrdata_en` and `dfi_rddata_en` equal bits 4 and 5.
- R6: In software mode, on every cycle other than an issue cycle, the four command lines are high and both data enables are low.
- R7: A write to the issue offset with data bit 0 clear emits no command. The issue offset always reads as 0.
- R8: When control bit 0 is 1, every DFI output equals the matching controller input in the same cycle. Issue writes then have no effect on the outputs.
- R9: Writing the command register by itself emits no command.
- R10: Command value 0x0F drives all four command lines low (mode-register set). Value 0x03 drives only `dfi_cs_n` and `dfi_we_n` low (ZQ calibration).
- R11: Writes to offsets other than the five listed change no register and no output. Reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| ctl_cs_n | input | 1 | Controller chip select |
| ctl_ras_n | input | 1 | Controller RAS |
| ctl_cas_n | input | 1 | Controller CAS |
| ctl_we_n | input | 1 | Controller WE |
| ctl_address | input | ADDR_W | Controller address |
| ctl_bank | input | BANK_W | Controller bank |
| ctl_cke | input | 1 | Controller clock enable |
| ctl_odt | input | 1 | Controller termination |
| ctl_reset_n | input | 1 | Controller memory reset |
| ctl_wrdata_en | input | 1 | Controller write-data enable |
| ctl_rddata_en | input | 1 | Controller read-data enable |
| dfi_cs_n | output | 1 | Chip select to PHY |
| dfi_ras_n | output | 1 | RAS to PHY |
| dfi_cas_n | output | 1 | CAS to PHY |
| dfi_we_n | output | 1 | WE to PHY |
| dfi_address | output | ADDR_W | Address to PHY |
| dfi_bank | output | BANK_W | Bank to PHY |
| dfi_cke | output | 1 | Clock enable to PHY |
| dfi_odt | output | 1 | Termination to PHY |
| dfi_reset_n | output | 1 | Memory reset to PHY |
| dfi_wrdata_en | output | 1 | Write-data enable to PHY |
| dfi_rddata_en | output | 1 | Read-data enable to PHY |

## Verification
The injection path is driven with random command, address, bank and control values, each followed by an issue write. Every output is compared on the issue cycle and on the cycle after it, which separates a correct one-shot pulse from a stuck or missing strobe. The directed mode-register-set and ZQ encodings expose swapped command bit positions. All-ones writes and writes to unmapped offsets expose readback masking and stray decodes. In hardware mode, random controller phases check that every output bit is passed through with no register swap and no leaking software value, including while issue writes arrive.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;

   localparam int unsigned OFF_CTRL  = 32'h00;
   localparam int unsigned OFF_CMD   = 32'h04;
   localparam int unsigned OFF_ISSUE = 32'h08;
   localparam int unsigned OFF_ADDR  = 32'h0C;
   localparam int unsigned OFF_BANK  = 32'h10;
   localparam int unsigned MIN_BUS_AW = 5;

   // bit0 hardware select, bit1 cke, bit2 odt, bit3 reset_n
   typedef struct packed {
      logic reset_n;
      logic odt;
      logic cke;
      logic hw_sel;
   } ctrl_t;

   // bit0 cs, bit1 we, bit2 cas, bit3 ras, bit4 wr enable, bit5 rd enable
   typedef struct packed {
      logic rd_en;
      logic wr_en;
      logic ras;
      logic cas;
      logic we;
      logic cs;
   } cmd_t;

   typedef enum logic [2:0] {
      SEL_CTRL, SEL_CMD, SEL_ISSUE, SEL_ADDR, SEL_BANK, SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_off(input logic [31:0] off);
      case (off)
         OFF_CTRL:  return SEL_CTRL;
         OFF_CMD:   return SEL_CMD;
         OFF_ISSUE: return SEL_ISSUE;
         OFF_ADDR:  return SEL_ADDR;
         OFF_BANK:  return SEL_BANK;
         default:   return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dfi_inj_regs.sv
module dfi_inj_regs
   import dfi_inj_pkg::*;
#(
   parameter int unsigned BUS_AW = 5,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output ctrl_t             ctrl_q,
   output cmd_t              cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BANK_W-1:0] bank_q,
   output logic              issue_q
);

   localparam int unsigned CTRL_W = $bits(ctrl_t);
   localparam int unsigned CMD_W  = $bits(cmd_t);

   reg_sel_e    sel;
   logic        wr_stb;
   logic        rd_stb;
   logic [31:0] rd_mux;
   wire         unused_wdata = ^bus_wdata;

   assign sel    = decode_off(32'(bus_addr));
   assign wr_stb = bus_req & bus_we;
   assign rd_stb = bus_req & ~bus_we;

   always_comb begin
      case (sel)
         SEL_CTRL: rd_mux = 32'(ctrl_q);
         SEL_CMD:  rd_mux = 32'(cmd_q);
         SEL_ADDR: rd_mux = 32'(addr_q);
         SEL_BANK: rd_mux = 32'(bank_q);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         cmd_q      <= '0;
         addr_q     <= '0;
         bank_q     <= '0;
         issue_q    <= 1'b0;
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         issue_q    <= wr_stb && (sel == SEL_ISSUE) && bus_wdata[0];
         bus_rvalid <= rd_stb;
         if (rd_stb) bus_rdata <= rd_mux;
         if (wr_stb) begin
            case (sel)
               SEL_CTRL: ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
               SEL_CMD:  cmd_q  <= cmd_t'(bus_wdata[CMD_W-1:0]);
               SEL_ADDR: addr_q <= bus_wdata[ADDR_W-1:0];
               SEL_BANK: bank_q <= bus_wdata[BANK_W-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dfi_inj_cmdgen.sv
module dfi_inj_cmdgen
   import dfi_inj_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BANK_W = 3,
   localparam int unsigned PH_W  = ADDR_W + BANK_W + 9
) (
   input  ctrl_t             ctrl_q,
   input  cmd_t              cmd_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [BANK_W-1:0] bank_q,
   input  logic              issue_q,
   output logic [PH_W-1:0]   sw_phase
);

   cmd_t live;
   wire  unused_sel = ctrl_q.hw_sel;

   // command bits are gated so that only the issue cycle carries them
   assign live = issue_q ? cmd_q : '0;

   // phase order: cke odt reset_n cs_n ras_n cas_n we_n wr_en rd_en bank addr
   assign sw_phase = {ctrl_q.cke, ctrl_q.odt, ctrl_q.reset_n,
                      ~live.cs, ~live.ras, ~live.cas, ~live.we,
                      live.wr_en, live.rd_en, bank_q, addr_q};

endmodule

// File: rtl/dfi_inj_mux.sv
module dfi_inj_mux #(
   parameter int unsigned          PH_W    = 28,
   parameter bit                   OUT_REG = 1'b0,
   parameter logic [PH_W-1:0]      IDLE    = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hw_sel,
   input  logic [PH_W-1:0] hw_phase,
   input  logic [PH_W-1:0] sw_phase,
   output logic [PH_W-1:0] out_phase
);

   logic [PH_W-1:0] pick;
   assign pick = hw_sel ? hw_phase : sw_phase;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) out_phase <= IDLE;
         else        out_phase <= pick;
      end
   end else begin : g_comb
      wire unused_clk = clk ^ rst_n;
      assign out_phase = pick;
   end

endmodule

// File: rtl/dfi_cmd_injector.sv
module dfi_cmd_injector
   import dfi_inj_pkg::*;
#(
   parameter int unsigned BUS_AW  = 5,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BANK_W  = 3,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   input  logic              ctl_cs_n,
   input  logic              ctl_ras_n,
   input  logic              ctl_cas_n,
   input  logic              ctl_we_n,
   input  logic [ADDR_W-1:0] ctl_address,
   input  logic [BANK_W-1:0] ctl_bank,
   input  logic              ctl_cke,
   input  logic              ctl_odt,
   input  logic              ctl_reset_n,
   input  logic              ctl_wrdata_en,
   input  logic              ctl_rddata_en,
   output logic              dfi_cs_n,
   output logic              dfi_ras_n,
   output logic              dfi_cas_n,
   output logic              dfi_we_n,
   output logic [ADDR_W-1:0] dfi_address,
   output logic [BANK_W-1:0] dfi_bank,
   output logic              dfi_cke,
   output logic              dfi_odt,
   output logic              dfi_reset_n,
   output logic              dfi_wrdata_en,
   output logic              dfi_rddata_en
);

   localparam int unsigned PH_W = ADDR_W + BANK_W + 9;
   localparam logic [PH_W-1:0] IDLE_PH = {3'b000, 4'b1111, 2'b00, {(ADDR_W+BANK_W){1'b0}}};

   if (BUS_AW < MIN_BUS_AW || BUS_AW > 32) begin : g_bad_aw
      $error("BUS_AW must lie in 5..32");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 1..32");
   end
   if (BANK_W < 1 || BANK_W > 32) begin : g_bad_bank
      $error("BANK_W must lie in 1..32");
   end

   ctrl_t             ctrl_q;
   cmd_t              cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BANK_W-1:0] bank_q;
   logic              issue_q;
   logic              hw_sel;
   logic [PH_W-1:0]   sw_phase;
   logic [PH_W-1:0]   hw_phase;
   logic [PH_W-1:0]   out_phase;

   assign hw_sel = ctrl_q.hw_sel;

   dfi_inj_regs #(.BUS_AW(BUS_AW), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .ctrl_q(ctrl_q), .cmd_q(cmd_q), .addr_q(addr_q), .bank_q(bank_q), .issue_q(issue_q)
   );

   dfi_inj_cmdgen #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) cmdgen_i (
      .ctrl_q(ctrl_q), .cmd_q(cmd_q), .addr_q(addr_q), .bank_q(bank_q),
      .issue_q(issue_q), .sw_phase(sw_phase)
   );

   assign hw_phase = {ctl_cke, ctl_odt, ctl_reset_n, ctl_cs_n, ctl_ras_n, ctl_cas_n,
                      ctl_we_n, ctl_wrdata_en, ctl_rddata_en, ctl_bank, ctl_address};

   dfi_inj_mux #(.PH_W(PH_W), .OUT_REG(OUT_REG), .IDLE(IDLE_PH)) mux_i (
      .clk(clk), .rst_n(rst_n), .hw_sel(hw_sel),
      .hw_phase(hw_phase), .sw_phase(sw_phase), .out_phase(out_phase)
   );

   assign {dfi_cke, dfi_odt, dfi_reset_n, dfi_cs_n, dfi_ras_n, dfi_cas_n,
           dfi_we_n, dfi_wrdata_en, dfi_rddata_en, dfi_bank, dfi_address} = out_phase;

endmodule

// File: rtl/dfi_inj_chk.sv
module dfi_inj_chk
   import dfi_inj_pkg::*;
#(
   parameter int unsigned BUS_AW  = 5,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned BANK_W  = 3,
   parameter bit          OUT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic              bus_wdata0,
   input logic [31:0]       bus_rdata,
   input logic              bus_rvalid,
   input logic              hw_sel,
   input logic [2:0]        ctrl_lvl,
   input logic              ctl_cs_n,
   input logic              ctl_ras_n,
   input logic              ctl_cas_n,
   input logic              ctl_we_n,
   input logic [ADDR_W-1:0] ctl_address,
   input logic [BANK_W-1:0] ctl_bank,
   input logic              ctl_cke,
   input logic              dfi_cs_n,
   input logic              dfi_ras_n,
   input logic              dfi_cas_n,
   input logic              dfi_we_n,
   input logic [ADDR_W-1:0] dfi_address,
   input logic [BANK_W-1:0] dfi_bank,
   input logic              dfi_cke,
   input logic              dfi_odt,
   input logic              dfi_reset_n,
   input logic              dfi_wrdata_en,
   input logic              dfi_rddata_en
);

   logic issue_wr;
   logic issue_rd;
   assign issue_wr = bus_req && bus_we && (bus_addr == BUS_AW'(OFF_ISSUE)) && bus_wdata0;
   assign issue_rd = bus_req && !bus_we && (bus_addr == BUS_AW'(OFF_ISSUE));

   assert_issue_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_rd |=> (bus_rvalid && bus_rdata == 32'h0));

   if (!OUT_REG) begin : g_comb_chk
      assert_hw_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
         hw_sel |-> (dfi_cs_n == ctl_cs_n && dfi_ras_n == ctl_ras_n &&
                     dfi_cas_n == ctl_cas_n && dfi_we_n == ctl_we_n &&
                     dfi_address == ctl_address && dfi_bank == ctl_bank &&
                     dfi_cke == ctl_cke));

      assert_nop_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!hw_sel && !$past(issue_wr)) |->
            (dfi_cs_n && dfi_ras_n && dfi_cas_n && dfi_we_n &&
             !dfi_wrdata_en && !dfi_rddata_en));

      assert_levels_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !hw_sel |-> (dfi_cke == ctrl_lvl[0] && dfi_odt == ctrl_lvl[1] &&
                      dfi_reset_n == ctrl_lvl[2]));

      assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!hw_sel && !dfi_cs_n && !issue_wr) |=> (hw_sel || dfi_cs_n));
   end

endmodule

bind dfi_cmd_injector dfi_inj_chk #(
   .BUS_AW(BUS_AW), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .OUT_REG(OUT_REG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata0(bus_wdata[0]), .bus_rdata(bus_rdata),
   .bus_rvalid(bus_rvalid), .hw_sel(hw_sel),
   .ctrl_lvl({ctrl_q.reset_n, ctrl_q.odt, ctrl_q.cke}),
   .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
   .ctl_we_n(ctl_we_n), .ctl_address(ctl_address), .ctl_bank(ctl_bank),
   .ctl_cke(ctl_cke),
   .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n), .dfi_cas_n(dfi_cas_n),
   .dfi_we_n(dfi_we_n), .dfi_address(dfi_address), .dfi_bank(dfi_bank),
   .dfi_cke(dfi_cke), .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n),
   .dfi_wrdata_en(dfi_wrdata_en), .dfi_rddata_en(dfi_rddata_en)
);

// File: tb/dfi_cmd_injector_tb_top.sv
module dfi_cmd_injector_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int ADW = 16;
   localparam int BKW = 3;
   localparam int PW = ADW + BKW + 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req = 1'b0;
   logic bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic bus_rvalid;
   logic [PW-1:0] ctl_v = '0;
   logic [PW-1:0] obs;

   logic dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n, dfi_cke, dfi_odt, dfi_reset_n;
   logic dfi_wrdata_en, dfi_rddata_en;
   logic [ADW-1:0] dfi_address;
   logic [BKW-1:0] dfi_bank;

   int n_checks = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [3:0] sh_ctrl = '0;
   logic [5:0] sh_cmd = '0;
   logic [ADW-1:0] sh_addr = '0;
   logic [BKW-1:0] sh_bank = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dfi_cmd_injector dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid),
      .ctl_cke(ctl_v[27]), .ctl_odt(ctl_v[26]), .ctl_reset_n(ctl_v[25]),
      .ctl_cs_n(ctl_v[24]), .ctl_ras_n(ctl_v[23]), .ctl_cas_n(ctl_v[22]),
      .ctl_we_n(ctl_v[21]), .ctl_wrdata_en(ctl_v[20]), .ctl_rddata_en(ctl_v[19]),
      .ctl_bank(ctl_v[18:16]), .ctl_address(ctl_v[15:0]),
      .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n), .dfi_cas_n(dfi_cas_n),
      .dfi_we_n(dfi_we_n), .dfi_address(dfi_address), .dfi_bank(dfi_bank),
      .dfi_cke(dfi_cke), .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n),
      .dfi_wrdata_en(dfi_wrdata_en), .dfi_rddata_en(dfi_rddata_en)
   );

   assign obs = {dfi_cke, dfi_odt, dfi_reset_n, dfi_cs_n, dfi_ras_n, dfi_cas_n,
                 dfi_we_n, dfi_wrdata_en, dfi_rddata_en, dfi_bank, dfi_address};

   function automatic logic [PW-1:0] exp_phase(input logic [3:0] c, input logic [5:0] m,
         input logic [ADW-1:0] a, input logic [BKW-1:0] b, input bit iss,
         input logic [PW-1:0] hw);
      logic [5:0] g;
      if (c[0]) return hw;
      g = iss ? m : 6'h0;
      return {c[1], c[2], c[3], ~g[0], ~g[3], ~g[2], ~g[1], g[4], g[5], b, a};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_obs(input bit iss, input string req, input string what);
      logic [PW-1:0] e;
      e = exp_phase(sh_ctrl, sh_cmd, sh_addr, sh_bank, iss, ctl_v);
      check(obs === e, req, what, 64'(obs), 64'(e));
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
      case (a)
         5'h00: sh_ctrl = d[3:0];
         5'h04: sh_cmd = d[5:0];
         5'h0C: sh_addr = d[ADW-1:0];
         5'h10: sh_bank = d[BKW-1:0];
         default: ;
      endcase
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      check(bus_rvalid === 1'b1, "R2", "rvalid", 64'(bus_rvalid), 64'd1);
      bus_req = 1'b0;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string req);
      logic [31:0] d;
      rd(a, d);
      check(d === e, req, "readback", 64'(d), 64'(e));
   endtask

   task automatic issue_and_check(input string req);
      wr(5'h08, 32'h1);
      check_obs(1'b1, req, "issue cycle");
      @(negedge clk);
      check_obs(1'b0, "R6", "cycle after issue");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_obs(1'b0, "R1", "reset outputs");
      check(obs === {3'b000, 4'b1111, 2'b00, 19'h0}, "R1", "idle literal",
            64'(obs), 64'({3'b000, 4'b1111, 2'b00, 19'h0}));
      rd_chk(5'h00, 32'h0, "R1");

      // R2 readback masks
      wr(5'h00, 32'hFFFF_FFFE);
      rd_chk(5'h00, 32'hE, "R2");
      check_obs(1'b0, "R3", "levels follow control");
      wr(5'h04, 32'hFFFF_FFFF);
      check_obs(1'b0, "R9", "command write alone");
      @(negedge clk);
      check_obs(1'b0, "R9", "command write alone later");
      rd_chk(5'h04, 32'h3F, "R2");
      wr(5'h0C, 32'hABCD_1234);
      rd_chk(5'h0C, 32'h1234, "R2");
      wr(5'h10, 32'hFFFF_FFFF);
      rd_chk(5'h10, 32'h7, "R2");
      check_obs(1'b0, "R4", "address and bank");

      // R10 mode-register set and ZQ
      wr(5'h0C, 32'h0920); wr(5'h10, 32'h0); wr(5'h04, 32'h0F);
      issue_and_check("R10");
      check(1'b1, "R10", "mrs issued", 0, 0);
      wr(5'h0C, 32'h0400); wr(5'h04, 32'h03);
      issue_and_check("R10");
      wr(5'h04, 32'h31);
      issue_and_check("R5");
      wr(5'h04, 32'h29);
      issue_and_check("R5");

      // R7 issue with bit0 clear
      wr(5'h04, 32'h3F);
      wr(5'h08, 32'hFFFF_FFFE);
      check_obs(1'b0, "R7", "no command on bit0 clear");
      rd_chk(5'h08, 32'h0, "R7");

      // R11 unmapped offsets
      wr(5'h14, 32'hFFFF_FFFF);
      check_obs(1'b0, "R11", "outputs after unmapped write");
      wr(5'h1C, 32'h0000_0001);
      check_obs(1'b0, "R11", "outputs after unmapped write 2");
      rd_chk(5'h14, 32'h0, "R11");
      rd_chk(5'h00, 32'(sh_ctrl), "R11");
      rd_chk(5'h04, 32'(sh_cmd), "R11");
      rd_chk(5'h0C, 32'(sh_addr), "R11");
      rd_chk(5'h10, 32'(sh_bank), "R11");

      // random software injections
      for (int i = 0; i < 40; i++) begin
         wr(5'h00, {$urandom} & 32'hFFFF_FFFE);
         check_obs(1'b0, "R3", "random control");
         wr(5'h04, $urandom);
         wr(5'h0C, $urandom);
         wr(5'h10, $urandom);
         check_obs(1'b0, "R4", "random address/bank");
         issue_and_check("R5");
      end

      // R8 hardware pass-through
      wr(5'h00, 32'h1);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         ctl_v = PW'({$urandom, $urandom});
         #1;
         check_obs(1'b0, "R8", "pass-through");
      end
      wr(5'h08, 32'h1);
      check_obs(1'b0, "R8", "issue ignored in hw mode");
      ctl_v = PW'($urandom);
      #1;
      check_obs(1'b0, "R8", "pass-through after issue");

      // back to software
      wr(5'h00, 32'hA);
      check_obs(1'b0, "R3", "back to software");
      issue_and_check("R5");

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule